// File: doc/BRIEF.md
# Page Frame Replacement Engine

The engine keeps a table of which virtual page sits in each of a configurable number of physical frames (two to eight built in, fewer selectable at run time). Page references arrive one at a time over a valid/ready handshake. For each one the engine reports, one cycle later, whether the page was already resident (a hit) or not (a fault), and which frame the page now occupies.

On a fault the engine fills the lowest-numbered empty frame if one exists. Otherwise it picks a victim under the selected policy: either the page loaded earliest (first-in-first-out) or the page referenced least recently (least-recently-used). When it evicts a page it reports the evicted page number and flags a write-back if that page was written while resident. A saturating counter totals the faults since the last clear. This makes the engine usable as a hardware fault model beside a memory system, or as an on-chip study aid for replacement behaviour, including the case where adding frames under first-in-first-out raises the fault count.

Top module: `frame_repl_engine`

## Requirements
- R1: A reference to a page resident in an active frame gives `rsp_hit`=1 and `rsp_frame` equal to that frame, with no eviction and no change to `fault_count`.
- R2: `req_ready` is high whenever `clear` is low and low while `clear` is high. An accepted reference (valid and ready high at a clock edge) gives `rsp_valid`=1 in the following cycle, together with its result fields.
- R3: While an active frame is empty, a fault fills the lowest-indexed empty frame and reports `rsp_evict`=0.
- R4: With `policy_i`=0 (first-in-first-out), a fault on a full table evicts the page loaded earliest. Hits do not change this order.
- R5: With `policy_i`=1 (least-recently-used), a fault on a full table evicts the page whose latest reference is oldest. Every hit makes the page the most recent.
- R6: An eviction reports `rsp_evict`=1, `rsp_hit`=0, `rsp_frame` equal to the victim frame and `rsp_evict_page` equal to the page that frame held.
- R7: A reference with `req_write`=1 marks its frame as modified, and a fill or replacement with `req_write`=0 marks it clean. `rsp_writeback` is 1 exactly when the evicted page was modified.
- R8: `fault_count` rises by one in the same cycle as each fault response and holds at its all-ones value once it gets there.
- R9: A cycle with `clear` high empties every frame, zeroes `fault_count` and suppresses `rsp_valid` in the next cycle.
- R10: `policy_i` and `nframes_i` are taken in only while no frame is occupied. Later changes have no effect until the next clear. An `nframes_i` of 0 selects one frame, and a value above `NUM_FRAMES` selects `NUM_FRAMES`.
- R11: The reference string 1,2,3,4,1,2,5,1,2,3,4,5 gives 9 faults under first-in-first-out with 3 frames, 10 under least-recently-used with 3 frames, and 10 under first-in-first-out with 4 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| clear | input | 1 | Empties the table and zeroes the fault counter |
| policy_i | input | 1 | 0 = first-in-first-out, 1 = least-recently-used |
| nframes_i | input | $clog2(NUM_FRAMES+1) | Number of frames in use |
| req_valid | input | 1 | Reference present |
| req_ready | output | 1 | Engine accepts a reference |
| req_page | input | PAGE_W | Referenced page number |
| req_write | input | 1 | Reference modifies the page |
| rsp_valid | output | 1 | Result fields valid |
| rsp_hit | output | 1 | Page was resident |
| rsp_frame | output | $clog2(NUM_FRAMES) | Frame now holding the page |
| rsp_evict | output | 1 | A resident page was displaced |
| rsp_evict_page | output | PAGE_W | Page number displaced |
| rsp_writeback | output | 1 | Displaced page was modified |
| fault_count | output | CNT_W | Saturating fault total since clear |

## Verification
The bench builds the engine with eight frames, four-bit page numbers and a six-bit fault counter. The small page space makes hits frequent in pseudo-random strings, so every active frame count from one to eight is swept under both policies. The short counter lets the bench drive it into saturation within a few dozen faults. Fixed strings confirm the published fault totals, the lock on configuration while frames are occupied, and the clamping of out-of-range frame counts.

// File: rtl/fre_pkg.sv
package fre_pkg;
   typedef enum logic [0:0] {
      POL_FIFO = 1'b0,
      POL_LRU  = 1'b1
   } pol_e;
endpackage

// File: rtl/fre_tag_match.sv
module fre_tag_match #(
   parameter int N      = 8,
   parameter int IW     = 3,
   parameter int PAGE_W = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N-1:0]               valid_vec,
   input  logic [N-1:0]               act_mask,
   input  logic [N-1:0][PAGE_W-1:0]   page_vec,
   input  logic [PAGE_W-1:0]          probe,
   output logic                       hit,
   output logic [IW-1:0]              hit_idx
);
   logic [N-1:0] match_vec;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match_vec[i] = valid_vec[i] & act_mask[i] & (page_vec[i] == probe);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_vec[i]) hit_idx = IW'(i);
      end
   end

   assign hit = |match_vec;

   // R1: a page is never resident in two frames at once
   unique_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
endmodule

// File: rtl/fre_age_rank.sv
module fre_age_rank #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  touch,
   input  logic                  touch_new,
   input  logic [IW-1:0]         touch_idx,
   input  logic [N-1:0]          valid_vec,
   output logic [N-1:0][IW-1:0]  rank_o
);
   logic [N-1:0][IW-1:0] rank_q;
   logic [IW:0]          ref_rank;
   logic [N-1:0]         newest_vec;

   // a newly loaded page ages every resident page; a refreshed one ages only the newer ones
   assign ref_rank = touch_new ? (IW+1)'(N) : {1'b0, rank_q[touch_idx]};

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rank_q <= '0;
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (touch_idx == IW'(i)) begin
               rank_q[i] <= '0;
            end else if (valid_vec[i] && ({1'b0, rank_q[i]} < ref_rank)) begin
               rank_q[i] <= rank_q[i] + 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_new
      assign newest_vec[i] = valid_vec[i] && (rank_q[i] == '0);
   end

   assign rank_o = rank_q;

   // R4: at most one resident frame holds the newest position
   newest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(newest_vec));
endmodule

// File: rtl/fre_victim_pick.sv
module fre_victim_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          valid_vec,
   input  logic [N-1:0]          act_mask,
   input  logic [N-1:0][IW-1:0]  rank_i,
   input  logic [IW-1:0]         oldest_rank,
   output logic                  free_avail,
   output logic [IW-1:0]         free_idx,
   output logic [IW-1:0]         victim_idx
);
   logic [N-1:0] free_vec;
   logic [N-1:0] old_vec;

   for (genvar i = 0; i < N; i++) begin : g_flag
      assign free_vec[i] = act_mask[i] & ~valid_vec[i];
      assign old_vec[i]  = act_mask[i] & valid_vec[i] & (rank_i[i] == oldest_rank);
   end

   always_comb begin
      free_idx   = '0;
      victim_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_vec[i]) free_idx = IW'(i);
         if (old_vec[i])  victim_idx = IW'(i);
      end
   end

   assign free_avail = |free_vec;

   // R4 / R5: a full table always has exactly one oldest frame
   one_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !free_avail |-> $onehot(old_vec));
endmodule

// File: rtl/frame_repl_engine.sv
module frame_repl_engine
   import fre_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   parameter int PAGE_W     = 20,
   parameter int CNT_W      = 16,
   localparam int IW        = $clog2(NUM_FRAMES),
   localparam int NF_W      = $clog2(NUM_FRAMES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               policy_i,
   input  logic [NF_W-1:0]    nframes_i,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [PAGE_W-1:0]  req_page,
   input  logic               req_write,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic [IW-1:0]      rsp_frame,
   output logic               rsp_evict,
   output logic [PAGE_W-1:0]  rsp_evict_page,
   output logic               rsp_writeback,
   output logic [CNT_W-1:0]   fault_count
);
   if (NUM_FRAMES < 2 || NUM_FRAMES > 8) begin : g_bad_frames
      $error("NUM_FRAMES must lie between 2 and 8");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("PAGE_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   localparam logic [NF_W-1:0] NF_MAX = NF_W'(NUM_FRAMES);

   logic [NUM_FRAMES-1:0]             fr_valid;
   logic [NUM_FRAMES-1:0]             fr_dirty;
   logic [NUM_FRAMES-1:0][PAGE_W-1:0] fr_page;
   logic [NUM_FRAMES-1:0][IW-1:0]     fr_rank;
   logic [NUM_FRAMES-1:0]             act_mask;

   pol_e              cfg_pol;
   logic [NF_W-1:0]   cfg_nfr;
   logic [NF_W-1:0]   nfr_in;
   logic              empty;

   logic              accept;
   logic              hit;
   logic [IW-1:0]     hit_idx;
   logic              free_avail;
   logic [IW-1:0]     free_idx;
   logic [IW-1:0]     vic_idx;
   logic [IW-1:0]     tgt_idx;
   logic              evict;
   logic              touch;

   assign empty     = ~|fr_valid;
   assign req_ready = ~clear;
   assign accept    = req_valid & ~clear;

   always_comb begin
      nfr_in = nframes_i;
      if (nframes_i == '0)         nfr_in = NF_W'(1);
      else if (nframes_i > NF_MAX) nfr_in = NF_MAX;
   end

   for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_act
      assign act_mask[i] = NF_W'(i) < cfg_nfr;
   end

   fre_tag_match #(.N(NUM_FRAMES), .IW(IW), .PAGE_W(PAGE_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_vec (fr_valid),
      .act_mask  (act_mask),
      .page_vec  (fr_page),
      .probe     (req_page),
      .hit       (hit),
      .hit_idx   (hit_idx)
   );

   fre_victim_pick #(.N(NUM_FRAMES), .IW(IW)) u_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_vec   (fr_valid),
      .act_mask    (act_mask),
      .rank_i      (fr_rank),
      .oldest_rank (IW'(cfg_nfr - 1'b1)),
      .free_avail  (free_avail),
      .free_idx    (free_idx),
      .victim_idx  (vic_idx)
   );

   assign evict   = ~hit & ~free_avail;
   assign tgt_idx = hit ? hit_idx : (free_avail ? free_idx : vic_idx);
   assign touch   = accept & (~hit | (cfg_pol == POL_LRU));

   fre_age_rank #(.N(NUM_FRAMES), .IW(IW)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .touch     (touch),
      .touch_new (~hit),
      .touch_idx (tgt_idx),
      .valid_vec (fr_valid),
      .rank_o    (fr_rank)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fr_valid       <= '0;
         fr_dirty       <= '0;
         fr_page        <= '0;
         cfg_pol        <= POL_FIFO;
         cfg_nfr        <= NF_MAX;
         fault_count    <= '0;
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_frame      <= '0;
         rsp_evict      <= 1'b0;
         rsp_evict_page <= '0;
         rsp_writeback  <= 1'b0;
      end else begin
         if (empty) begin
            cfg_pol <= pol_e'(policy_i);
            cfg_nfr <= nfr_in;
         end
         if (clear) begin
            fr_valid    <= '0;
            fr_dirty    <= '0;
            fault_count <= '0;
            rsp_valid   <= 1'b0;
         end else begin
            rsp_valid <= accept;
            if (accept) begin
               rsp_hit        <= hit;
               rsp_frame      <= tgt_idx;
               rsp_evict      <= evict;
               rsp_evict_page <= fr_page[vic_idx];
               rsp_writeback  <= evict & fr_dirty[vic_idx];
               if (!hit && fault_count != '1) fault_count <= fault_count + 1'b1;
               for (int i = 0; i < NUM_FRAMES; i++) begin
                  if (tgt_idx == IW'(i)) begin
                     if (hit) begin
                        if (req_write) fr_dirty[i] <= 1'b1;
                     end else begin
                        fr_valid[i] <= 1'b1;
                        fr_page[i]  <= req_page;
                        fr_dirty[i] <= req_write;
                     end
                  end
               end
            end
         end
      end
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   // R3
   frame_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (NF_W'(rsp_frame) < cfg_nfr));
   // R6
   evict_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_evict |-> !rsp_hit);
   // R7
   wb_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_writeback |-> rsp_evict);
   // R8
   fault_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && !$past(clear) && $past(fault_count) != '1)
         |-> fault_count == CNT_W'($past(fault_count) + 1'b1));
   // R9
   clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (fault_count == '0 && !rsp_valid));
   // R10
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty |=> ($stable(cfg_pol) && $stable(cfg_nfr)));
endmodule

// File: tb/tb_frame_repl_engine.sv
`timescale 1ns/1ps
module tb_frame_repl_engine;
   localparam int NF = 8;
   localparam int PW = 4;
   localparam int CW = 6;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic          policy_i = 1'b0;
   logic [3:0]    nframes_i = 4'd8;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [PW-1:0] req_page = '0;
   logic          req_write = 1'b0;
   logic          rsp_valid, rsp_hit, rsp_evict, rsp_writeback;
   logic [2:0]    rsp_frame;
   logic [PW-1:0] rsp_evict_page;
   logic [CW-1:0] fault_count;

   int n_chk = 0;
   int n_fail = 0;

   // bench model state
   int m_pol, m_nfr, m_fault, m_tick;
   int m_pg[NF];
   int m_ts[NF];
   bit m_v[NF];
   bit m_d[NF];

   frame_repl_engine #(.NUM_FRAMES(NF), .PAGE_W(PW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .policy_i(policy_i),
      .nframes_i(nframes_i), .req_valid(req_valid), .req_ready(req_ready),
      .req_page(req_page), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_frame(rsp_frame), .rsp_evict(rsp_evict),
      .rsp_evict_page(rsp_evict_page), .rsp_writeback(rsp_writeback),
      .fault_count(fault_count)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset(input int pol, input int raw);
      m_pol = pol;
      m_nfr = (raw == 0) ? 1 : ((raw > NF) ? NF : raw);
      m_fault = 0;
      m_tick = 0;
      for (int j = 0; j < NF; j++) begin
         m_v[j] = 0; m_d[j] = 0; m_pg[j] = 0; m_ts[j] = 0;
      end
   endtask

   task automatic do_clear(input int pol, input int raw);
      @(negedge clk);
      clear = 1'b1;
      policy_i = pol[0];
      nframes_i = raw[3:0];
      #1 chk(req_ready == 1'b0, "R2", "ready during clear", int'(req_ready), 0);
      @(negedge clk);
      clear = 1'b0;
      chk(fault_count == '0, "R9", "count after clear", int'(fault_count), 0);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid after clear", int'(rsp_valid), 0);
      @(negedge clk);
      model_reset(pol, raw);
   endtask

   task automatic do_ref(input int p, input bit w);
      int hj, fj, vj, e_fr, e_evp;
      bit e_hit, e_ev, e_wb;
      string ftag;
      hj = -1; e_ev = 0; e_wb = 0; e_evp = 0;
      for (int j = 0; j < m_nfr; j++) if (m_v[j] && m_pg[j] == p) hj = j;
      if (hj >= 0) begin
         e_hit = 1; e_fr = hj; ftag = "R1";
         if (w) m_d[hj] = 1;
         if (m_pol == 1) m_ts[hj] = m_tick;
      end else begin
         e_hit = 0; fj = -1;
         for (int j = m_nfr - 1; j >= 0; j--) if (!m_v[j]) fj = j;
         if (fj >= 0) begin
            e_fr = fj; ftag = "R3";
         end else begin
            vj = 0;
            for (int j = 1; j < m_nfr; j++) if (m_ts[j] < m_ts[vj]) vj = j;
            e_fr = vj; e_ev = 1; e_evp = m_pg[vj]; e_wb = m_d[vj];
            ftag = (m_pol == 1) ? "R5" : "R4";
         end
         m_v[e_fr] = 1; m_pg[e_fr] = p; m_d[e_fr] = w; m_ts[e_fr] = m_tick;
         if (m_fault < CMAX) m_fault++;
      end
      m_tick++;
      req_valid = 1'b1;
      req_page = p[PW-1:0];
      req_write = w;
      #1 chk(req_ready == 1'b1, "R2", "ready when idle", int'(req_ready), 1);
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
      chk(rsp_hit == e_hit, "R1", "hit flag", int'(rsp_hit), int'(e_hit));
      chk(int'(rsp_frame) == e_fr, ftag, "frame", int'(rsp_frame), e_fr);
      chk(rsp_evict == e_ev, "R6", "evict flag", int'(rsp_evict), int'(e_ev));
      if (e_ev)
         chk(int'(rsp_evict_page) == e_evp, "R6", "evicted page",
             int'(rsp_evict_page), e_evp);
      chk(rsp_writeback == e_wb, "R7", "writeback", int'(rsp_writeback), int'(e_wb));
      chk(int'(fault_count) == m_fault, "R8", "fault count", int'(fault_count), m_fault);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic run_belady(input int pol, input int nf, input int exp_total);
      int seq[12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
      do_clear(pol, nf);
      for (int k = 0; k < 12; k++) do_ref(seq[k], 1'b0);
      chk(int'(fault_count) == exp_total, "R11", "string fault total",
          int'(fault_count), exp_total);
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid at reset", int'(rsp_valid), 0);
      chk(fault_count == '0, "R9", "count at reset", int'(fault_count), 0);

      // R11: published totals, including the rise from 3 to 4 frames
      run_belady(0, 3, 9);
      run_belady(1, 3, 10);
      run_belady(0, 4, 10);

      // R7: dirty victim then clean victim
      do_clear(0, 2);
      do_ref(1, 1'b1); do_ref(2, 1'b0); do_ref(3, 1'b0); do_ref(4, 1'b0);

      // R10: inputs changed while occupied are ignored
      do_clear(0, 3);
      do_ref(1, 1'b0); do_ref(2, 1'b0); do_ref(3, 1'b0);
      policy_i = 1'b1;
      nframes_i = 4'd8;
      do_ref(1, 1'b0);
      do_ref(4, 1'b0);
      chk(rsp_frame == 3'd0, "R10", "locked policy victim", int'(rsp_frame), 0);

      // R10: clamping of frame count
      do_clear(0, 0);
      do_ref(5, 1'b0); do_ref(6, 1'b0);
      chk(rsp_evict_page == 4'd5, "R10", "zero frames acts as one",
          int'(rsp_evict_page), 5);
      do_clear(1, 15);
      for (int k = 0; k < 9; k++) do_ref(k, 1'b0);
      chk(rsp_frame == 3'd0 && rsp_evict == 1'b1, "R10", "oversize clamps to max",
          int'(rsp_frame), 0);

      // sweep both policies across every active frame count
      lfsr = 16'hACE1;
      for (int pol = 0; pol < 2; pol++) begin
         for (int nf = 1; nf <= NF; nf++) begin
            do_clear(pol, nf);
            for (int k = 0; k < 48; k++) begin
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               do_ref(int'(lfsr[3:0]) % (nf + 3), lfsr[7]);
            end
         end
      end

      // R8: saturation
      do_clear(0, 1);
      for (int k = 0; k < 70; k++) do_ref(k % 2, 1'b0);
      chk(int'(fault_count) == CMAX, "R8", "saturated count", int'(fault_count), CMAX);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule